// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block derives two timing strobes from a fast system clock for a serial link. A runtime divisor gives the number of system clocks in one bit period. The block emits a one-cycle bit tick once per bit period for a transmitter. It also emits an oversample tick at eight times that rate for a receiver. Both strobes come from one shared timebase.

The divisor is captured into a working copy when reset is asserted and again at every bit-period wrap. A new divisor therefore never shortens or stretches the bit period already under way. The oversample interval is the captured divisor shifted right by three. The oversample counter restarts together with the bit counter, so the oversample ticks cannot drift against the bit tick. Each bit period holds exactly eight of them, and the last one falls in the same cycle as the bit tick. Any remainder of the division lengthens the last oversample interval. A divisor below two produces no ticks at all.

Top module: `baud_tick_gen`

## Requirements
- R1: `baud_tick` is high for exactly one clock cycle per bit period when the divisor D is at least 2.
- R2: Successive `baud_tick` pulses are exactly D clock cycles apart.
- R3: After reset is released, the first `baud_tick` is high directly after the D-th rising edge at which `rst` is low.
- R4: While `rst` is high, both `baud_tick` and `ovs_tick` are low from the first clock edge on.
- R5: For D of 8 or more, `ovs_tick` is high at offsets S, 2S, ... 7S after a `baud_tick`, where S = D >> 3 (truncated), and again in the cycle of the next `baud_tick`. That makes exactly eight oversample ticks per bit period.
- R6: When D is not a multiple of eight, the remainder falls into the last oversample interval. For example, with D = 85 the eighth tick comes 15 cycles after the seventh.
- R7: A divisor of 0 or 1 keeps both outputs low. When the divisor then changes to D of 2 or more, the first clock edge that sees the new value captures it. The first `baud_tick` follows D edges after that edge.
- R8: For D from 2 to 7, `ovs_tick` is high only in the cycles where `baud_tick` is high.
- R9: A divisor change made in the middle of a bit period leaves that period at the old length. It takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | DIV_W | System clocks per bit period |
| baud_tick | output | 1 | One-cycle bit-rate strobe |
| ovs_tick | output | 1 | One-cycle strobe at eight times the bit rate |

## Verification
The bit-period wrap and the eighth oversample event land in the same cycle. The oversample counter must also be restarted by that wrap rather than fire an extra interior tick. The bench provokes this with divisors that divide evenly by eight (80), with divisors that leave a remainder (85, 15) and with divisors too small to give an interior interval (5). It records the offset of every oversample tick inside a bit period. It then judges that the last offset equals the period and coincides with `baud_tick`, and that the tick count is eight, or one for the small divisors.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // A divisor is usable when it yields a period of two or more cycles.
  function automatic bit div_ok(input int unsigned d);
    return d >= 2;
  endfunction

  // Oversample interval: divisor shifted right by the oversample exponent.
  function automatic int unsigned ovs_step(input int unsigned d, input int unsigned lg);
    return d >> lg;
  endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             wrap,
  output logic [DIV_W-1:0] cur_div,
  output logic             div_ok
);
  logic [DIV_W-1:0] cur_div_q;

  assign div_ok  = baud_pkg::div_ok(32'(cur_div_q));
  assign cur_div = cur_div_q;

  // Capture in reset, at each wrap, and continuously while idle.
  always_ff @(posedge clk) begin
    if (rst || wrap || !div_ok) cur_div_q <= divisor;
  end
endmodule

// File: rtl/baud_bit_cnt.sv
module baud_bit_cnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             div_ok,
  output logic             wrap
);
  logic [DIV_W-1:0] bcnt_q;

  assign wrap = div_ok && (bcnt_q == cur_div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !div_ok || wrap) bcnt_q <= '0;
    else                        bcnt_q <= bcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_ovs_cnt.sv
module baud_ovs_cnt #(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             wrap,
  output logic             ovs_mid
);
  localparam int OVS_RATE = 1 << OVS_LOG2;
  localparam int SLOT_W   = OVS_LOG2;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(OVS_RATE - 1);

  logic [DIV_W-1:0]  step;
  logic [DIV_W-1:0]  ocnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slots_left;

  assign step       = DIV_W'(baud_pkg::ovs_step(32'(cur_div), OVS_LOG2));
  assign slots_left = slot_q < SLOT_LAST;
  assign ovs_mid    = (step != '0) && slots_left && (ocnt_q == step - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || wrap || step == '0) begin
      ocnt_q <= '0;
      slot_q <= '0;
    end else if (ovs_mid) begin
      ocnt_q <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else if (slots_left) begin
      ocnt_q <= ocnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_out.sv
module baud_tick_out (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic ovs_mid,
  output logic baud_tick,
  output logic ovs_tick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_tick <= 1'b0;
      ovs_tick  <= 1'b0;
    end else begin
      baud_tick <= wrap;
      ovs_tick  <= wrap || ovs_mid;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             baud_tick,
  output logic             ovs_tick
);
  logic [DIV_W-1:0] cur_div_w;
  logic             div_ok_w;
  logic             wrap_w;
  logic             ovs_mid_w;

  baud_div_latch #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .divisor(divisor), .wrap(wrap_w),
    .cur_div(cur_div_w), .div_ok(div_ok_w)
  );

  baud_bit_cnt #(.DIV_W(DIV_W)) bit_i (
    .clk(clk), .rst(rst), .cur_div(cur_div_w), .div_ok(div_ok_w), .wrap(wrap_w)
  );

  baud_ovs_cnt #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) ovs_i (
    .clk(clk), .rst(rst), .cur_div(cur_div_w), .wrap(wrap_w), .ovs_mid(ovs_mid_w)
  );

  baud_tick_out out_i (
    .clk(clk), .rst(rst), .wrap(wrap_w), .ovs_mid(ovs_mid_w),
    .baud_tick(baud_tick), .ovs_tick(ovs_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 3
) (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic ovs_tick,
  input logic div_ok_w,
  input logic wrap_w
);
  localparam int OVS_RATE = 1 << OVS_LOG2;

  int unsigned mid_seen;

  always_ff @(posedge clk) begin
    if (rst || baud_tick) mid_seen <= 0;
    else if (ovs_tick)    mid_seen <= mid_seen + 1;
  end

  // R4
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!baud_tick && !ovs_tick));

  // R1
  baud_single_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick);

  // R5
  ovs_align_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> ovs_tick);

  // R5
  ovs_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (ovs_tick && !baud_tick) |-> (mid_seen < OVS_RATE - 1));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !div_ok_w |=> (!baud_tick && !ovs_tick));

  // R2
  baud_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> baud_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) chk_i (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .ovs_tick(ovs_tick),
  .div_ok_w(div_ok_w), .wrap_w(wrap_w)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] divisor = '0;
  logic             baud_tick;
  logic             ovs_tick;

  int n_chk = 0;
  int n_bad = 0;
  int offs [0:63];
  int n_offs;
  int misalign;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen #(.DIV_W(DIV_W), .OVS_LOG2(3)) dut_i (
    .clk(clk), .rst(rst), .divisor(divisor),
    .baud_tick(baud_tick), .ovs_tick(ovs_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input int d);
    @(negedge clk);
    rst = 1'b1;
    divisor = DIV_W'(d);
    step(); step();
    rst = 1'b0;
  endtask

  // Counts negedges until baud_tick is seen high.
  task automatic wait_baud(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!baud_tick && n < 5000);
  endtask

  // Starting on a baud cycle, records ovs offsets up to the next baud tick.
  task automatic scan_period(output int len);
    len = 0;
    n_offs = 0;
    misalign = 0;
    do begin
      step();
      len++;
      if (ovs_tick && n_offs < 64) begin
        offs[n_offs] = len;
        n_offs++;
      end
      if (baud_tick && !ovs_tick) misalign++;
    end while (!baud_tick && len < 5000);
  endtask

  task automatic t_reset();
    int highs = 0;
    rst = 1'b1;
    divisor = DIV_W'(4);
    for (int i = 0; i < 8; i++) begin
      step();
      if (baud_tick || ovs_tick) highs++;
    end
    check(highs == 0, "R4 outputs low in reset", highs, 0);
  endtask

  task automatic t_first(input int d);
    int n;
    do_reset(d);
    wait_baud(n);
    check(n == d, "R3 first tick edge", n, d);
    step();
    check(!baud_tick, "R1 pulse one cycle", int'(baud_tick), 0);
  endtask

  task automatic t_period(input int d);
    int n, len;
    do_reset(d);
    wait_baud(n);
    scan_period(len);
    check(len == d, "R2 period", len, d);
    scan_period(len);
    check(len == d, "R2 second period", len, d);
  endtask

  task automatic t_ovs(input int d, input string req);
    int n, len, s, exp_off;
    s = d >> 3;
    do_reset(d);
    wait_baud(n);
    scan_period(len);
    check(n_offs == 8, {req, " ovs count"}, n_offs, 8);
    for (int k = 0; k < 7 && k < n_offs; k++) begin
      exp_off = (k + 1) * s;
      check(offs[k] == exp_off, {req, " ovs offset"}, offs[k], exp_off);
    end
    if (n_offs > 0)
      check(offs[n_offs-1] == d, {req, " last ovs with baud"}, offs[n_offs-1], d);
    check(misalign == 0, "R5 ovs with baud", misalign, 0);
  endtask

  task automatic t_small(input int d);
    int n, len;
    do_reset(d);
    wait_baud(n);
    scan_period(len);
    check(n_offs == 1, "R8 ovs count small divisor", n_offs, 1);
    check(offs[0] == d, "R8 ovs only with baud", offs[0], d);
  endtask

  task automatic t_idle();
    int highs = 0;
    int n, len;
    do_reset(0);
    for (int i = 0; i < 60; i++) begin
      step();
      if (baud_tick || ovs_tick) highs++;
    end
    divisor = DIV_W'(1);
    for (int i = 0; i < 60; i++) begin
      step();
      if (baud_tick || ovs_tick) highs++;
    end
    check(highs == 0, "R7 no ticks for divisor 0/1", highs, 0);
    divisor = DIV_W'(12);
    wait_baud(n);
    check(n == 13, "R7 restart after idle", n, 13);
    scan_period(len);
    check(len == 12, "R7 period after idle", len, 12);
  endtask

  task automatic t_change();
    int n, len;
    do_reset(40);
    wait_baud(n);
    for (int i = 0; i < 10; i++) step();
    divisor = DIV_W'(24);
    n = 10;
    do begin
      step();
      n++;
    end while (!baud_tick && n < 5000);
    check(n == 40, "R9 current period kept", n, 40);
    scan_period(len);
    check(len == 24, "R9 new period applied", len, 24);
  endtask

  initial begin
    t_reset();
    t_first(20);
    t_first(2);
    t_period(20);
    t_period(37);
    t_period(434);
    t_ovs(80, "R5");
    t_ovs(85, "R6");
    t_ovs(15, "R6");
    t_small(5);
    t_small(2);
    t_idle();
    t_change();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule